// File: doc/BRIEF.md
# Three-Level Extended-Address Page Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading three levels of translation tables from memory. Every table entry is 64 bits wide. The walk starts at a four-entry root table. The root table's base comes in alongside each virtual address. The walk then goes through a 512-entry directory and a 512-entry page table. The last entry read supplies a 24-bit frame number, and the 12-bit page offset is placed under it.

A client offers a request with a valid/ready pair. The walker fetches entries one at a time through a 64-bit read port that uses a request handshake and a response strobe. It then shows the outcome for exactly one cycle: either a physical address or a fault, together with the level of the last entry it read. An entry whose valid bit is clear ends the walk at once.

Top module: `xpw_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready` is 1 and both `mem_rd_valid` and `resp_valid` are 0.
- R2: The first read of a walk uses address `req_root + vaddr[31:30]*8`, with 36-bit wrap-around.
- R3: The second read uses address `{frame of root entry, 12'h000} + vaddr[29:21]*8`.
- R4: The third read uses address `{frame of directory entry, 12'h000} + vaddr[20:12]*8`.
- R5: When all three entries are valid, `resp_paddr` equals `{frame of page-table entry, vaddr[11:0]}` and `resp_fault` is 0.
- R6: The frame number is taken from entry bits [35:12], and bit 0 is the valid flag. Entry bits [63:36] and [11:1] have no effect on any address or result.
- R7: If an entry has bit 0 clear, the walk stops after that read. In that case `resp_fault` is 1, `resp_paddr` is 0, and `resp_level` is 0, 1 or 2 for the root, directory or page-table level. A walk that succeeds reports `resp_level` 2.
- R8: At most one read is outstanding at a time. While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address stay unchanged. No new read is issued until the response to the previous one has arrived.
- R9: `resp_valid` is a one-cycle pulse. `req_ready` is high only when the walker is idle, and never in the same cycle as `resp_valid` or `mem_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 36 | Physical base of the four-entry root table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| resp_valid | output | 1 | Result strobe, one cycle |
| resp_paddr | output | 36 | Translated physical address, 0 on fault |
| resp_fault | output | 1 | Walk ended on an entry whose valid bit was clear |
| resp_level | output | 2 | Level of the last entry read |

## Verification
Two events can coincide: the one-cycle result strobe, and the next request the client is already offering. The bench provokes this by raising `req_valid` for the next walk in the same cycle the result appears. It then checks that the request is refused during the result cycle, accepted in the cycle after it, and that the strobe is gone by then. A second overlap is a read held off by a low `mem_rd_ready` while earlier responses arrive with varying delay. The bench checks that the address stays unchanged and that a second read never overlaps an outstanding one. The bench sweeps all root indices and edge-case directory and table indices across several root bases. Its memory model computes entries by arithmetic and fills the ignored bits with noise.

// File: rtl/xpw_pkg.sv
package xpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_TOP,
        ST_READ_DIR,
        ST_READ_TBL,
        ST_DONE
    } xpw_state_e;

    typedef logic [1:0] xpw_lvl_t;

    localparam xpw_lvl_t LVL_TOP = 2'd0;
    localparam xpw_lvl_t LVL_DIR = 2'd1;
    localparam xpw_lvl_t LVL_TBL = 2'd2;

endpackage

// File: rtl/xpw_entry_addr.sv
// Selects the index field of the virtual address for the current level and
// forms the byte address of the entry within the current table.
module xpw_entry_addr #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 36,
    parameter int ENTRY_W = 64,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 9,
    parameter int LEVELS  = 3
) (
    input  logic [VA_W-1:0]      vaddr,
    input  logic [PA_W-1:0]      base,
    input  xpw_pkg::xpw_lvl_t    level,
    output logic [PA_W-1:0]      addr
);
    localparam int ENT_SH = $clog2(ENTRY_W / 8);

    logic [IDX_W-1:0] idx [LEVELS];
    logic [IDX_W-1:0] sel;
    logic             unused_off;

    // Level 0 takes the leftover upper bits; deeper levels take IDX_W each.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int LSB = OFF_W + (LEVELS - 1 - g) * IDX_W;
        localparam int W   = (g == 0) ? (VA_W - LSB) : IDX_W;
        assign idx[g] = IDX_W'(vaddr[LSB +: W]);
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == xpw_pkg::xpw_lvl_t'(i)) sel = idx[i];
        end
    end

    assign addr       = base + (PA_W'(sel) << ENT_SH);
    assign unused_off = ^vaddr[OFF_W-1:0];

endmodule

// File: rtl/xpw_entry_decode.sv
// Splits a table entry into its valid flag and frame number.
module xpw_entry_decode #(
    parameter int ENTRY_W = 64,
    parameter int PA_W    = 36,
    parameter int OFF_W   = 12
) (
    input  logic [ENTRY_W-1:0]    entry,
    output logic                  present,
    output logic [PA_W-OFF_W-1:0] frame
);
    logic unused_bits;

    assign present     = entry[0];
    assign frame       = entry[PA_W-1:OFF_W];
    assign unused_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:1]};

endmodule

// File: rtl/xpw_walker.sv
module xpw_walker #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 36,
    parameter int ENTRY_W = 64,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 9,
    parameter int LEVELS  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [PA_W-1:0]    req_root,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               resp_valid,
    output logic [PA_W-1:0]    resp_paddr,
    output logic               resp_fault,
    output logic [1:0]         resp_level
);
    import xpw_pkg::*;

    localparam int FRAME_W = PA_W - OFF_W;

    typedef struct packed {
        xpw_state_e      st;
        logic            issued;
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] paddr;
        logic            fault;
        xpw_lvl_t        lvl;
    } walk_t;

    walk_t               q, d;
    xpw_lvl_t            cur_lvl;
    logic                reading;
    logic                ent_present;
    logic [FRAME_W-1:0]  ent_frame;
    logic [PA_W-1:0]     ent_addr;

    xpw_entry_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) u_addr (
        .vaddr (q.va),
        .base  (q.base),
        .level (cur_lvl),
        .addr  (ent_addr)
    );

    xpw_entry_decode #(
        .ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_dec (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    always_comb begin
        case (q.st)
            ST_READ_DIR: cur_lvl = LVL_DIR;
            ST_READ_TBL: cur_lvl = LVL_TBL;
            default:     cur_lvl = LVL_TOP;
        endcase
        reading = (q.st == ST_READ_TOP) || (q.st == ST_READ_DIR) ||
                  (q.st == ST_READ_TBL);
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va     = req_vaddr;
                    d.base   = req_root;
                    d.issued = 1'b0;
                    d.st     = ST_READ_TOP;
                end
            end
            ST_READ_TOP, ST_READ_DIR, ST_READ_TBL: begin
                if (!q.issued && mem_rd_ready) begin
                    d.issued = 1'b1;
                end
                if (q.issued && mem_rsp_valid) begin
                    d.issued = 1'b0;
                    d.lvl    = cur_lvl;
                    if (!ent_present) begin
                        d.fault = 1'b1;
                        d.paddr = '0;
                        d.st    = ST_DONE;
                    end else if (q.st == ST_READ_TBL) begin
                        d.fault = 1'b0;
                        d.paddr = {ent_frame, q.va[OFF_W-1:0]};
                        d.st    = ST_DONE;
                    end else begin
                        d.base = {ent_frame, {OFF_W{1'b0}}};
                        d.st   = (q.st == ST_READ_TOP) ? ST_READ_DIR : ST_READ_TBL;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign mem_rd_valid = reading && !q.issued;
    assign mem_rd_addr  = ent_addr;
    assign resp_valid   = (q.st == ST_DONE);
    assign resp_paddr   = q.paddr;
    assign resp_fault   = q.fault;
    assign resp_level   = q.lvl;

endmodule

// File: rtl/xpw_walker_chk.sv
module xpw_walker_chk #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 36,
    parameter int ENTRY_W = 64,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 9,
    parameter int LEVELS  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [PA_W-1:0] req_root,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rsp_valid,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_paddr,
    input logic            resp_fault
);
    localparam int TOP_W  = VA_W - OFF_W - (LEVELS - 1) * IDX_W;
    localparam int ENT_SH = $clog2(ENTRY_W / 8);

    logic            out_q;
    logic            first_q;
    logic [VA_W-1:0] va_cap;
    logic [PA_W-1:0] root_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            first_q  <= 1'b0;
            va_cap   <= '0;
            root_cap <= '0;
        end else begin
            if (req_valid && req_ready) begin
                first_q  <= 1'b1;
                va_cap   <= req_vaddr;
                root_cap <= req_root;
            end else if (mem_rd_valid && mem_rd_ready) begin
                first_q  <= 1'b0;
            end
            if (mem_rd_valid && mem_rd_ready) out_q <= 1'b1;
            else if (mem_rsp_valid)           out_q <= 1'b0;
        end
    end

    p_top_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && first_q |->
            mem_rd_addr == root_cap + (PA_W'(va_cap[VA_W-1 -: TOP_W]) << ENT_SH));

    p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_fault |-> resp_paddr[OFF_W-1:0] == va_cap[OFF_W-1:0]);

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_paddr == '0);

    p_one_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !mem_rd_valid);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid && !resp_valid);

endmodule

bind xpw_walker xpw_walker_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W),
    .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_root      (req_root),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .resp_valid    (resp_valid),
    .resp_paddr    (resp_paddr),
    .resp_fault    (resp_fault)
);

// File: tb/xpw_walker_bench.sv
`timescale 1ns/1ps
module xpw_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [35:0] req_root = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [35:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic [35:0] resp_paddr;
    logic        resp_fault;
    logic [1:0]  resp_level;

    always #2 clk = ~clk;

    xpw_walker u_xpw_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_root      (req_root),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .resp_fault    (resp_fault),
        .resp_level    (resp_level)
    );

    int checks = 0, fails = 0;
    int mchecks = 0, mfails = 0;
    int rd_total = 0;
    logic [35:0] rd_log [8];

    // Entry contents as a function of address; ignored bits carry noise (R6).
    function automatic logic [63:0] ent(input logic [35:0] a);
        logic [63:0] h;
        h = ({28'h0, a} ^ ({28'h0, a} >> 7)) * 64'h9E3779B97F4A7C15;
        return {~h[63:36], h[47:24], h[10:0], (h[20:18] != 3'b000)};
    endfunction

    // Memory responder: random ready, 1..4 cycle latency, protocol checks (R8).
    initial begin
        logic [15:0] lfsr;
        logic        pend, prev_wait;
        int          cnt;
        logic [35:0] pend_addr, prev_addr;
        lfsr = 16'hACE1; pend = 1'b0; prev_wait = 1'b0; cnt = 0;
        pend_addr = '0; prev_addr = '0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (pend) begin
                if (cnt <= 1) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = ent(pend_addr);
                    pend = 1'b0;
                end else begin
                    cnt--;
                    mem_rsp_valid = 1'b0;
                    mem_rsp_data  = {lfsr, lfsr, lfsr, lfsr};
                end
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = {lfsr, ~lfsr, lfsr, ~lfsr};
            end
            if (prev_wait) begin
                mchecks++;
                if (!(mem_rd_valid && mem_rd_addr == prev_addr)) begin
                    mfails++;
                    $display("FAIL R8 stalled read changed: valid=%0b addr=%h expected valid=1 addr=%h",
                             mem_rd_valid, mem_rd_addr, prev_addr);
                end
            end
            mem_rd_ready = lfsr[0] | lfsr[3];
            if (mem_rd_valid && mem_rd_ready) begin
                mchecks++;
                if (pend || mem_rsp_valid) begin
                    mfails++;
                    $display("FAIL R8 read issued while one outstanding: actual=2 expected=1");
                end
                rd_log[rd_total & 7] = mem_rd_addr;
                rd_total++;
                pend = 1'b1;
                pend_addr = mem_rd_addr;
                cnt = int'(lfsr[2:1]) + 1;
            end
            prev_wait = mem_rd_valid && !mem_rd_ready;
            prev_addr = mem_rd_addr;
        end
    end

    task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic run(input logic [35:0] root, input logic [31:0] va);
        logic [35:0] ea [3];
        logic [35:0] b, epa;
        logic [63:0] e;
        logic [8:0]  idx;
        logic        efault;
        logic [1:0]  elvl;
        int          nexp, base_cnt, got, t;
        b = root; epa = '0; efault = 1'b0; elvl = 2'd0; nexp = 0;
        for (int l = 0; l < 3; l++) begin
            idx = (l == 0) ? {7'd0, va[31:30]} : (l == 1) ? va[29:21] : va[20:12];
            ea[l] = b + {24'd0, idx, 3'b000};
            e = ent(ea[l]);
            nexp = l + 1;
            elvl = 2'(l);
            if (!e[0]) begin efault = 1'b1; break; end
            b = {e[35:12], 12'h000};
            if (l == 2) epa = {e[35:12], va[11:0]};
        end
        // Offer the request at once, possibly in the previous result cycle.
        req_valid = 1'b1; req_vaddr = va; req_root = root;
        t = 0;
        while (!req_ready && t < 50) begin @(negedge clk); t++; end
        chk(req_ready && !resp_valid, "R9 accept cycle ready/strobe",
            {62'd0, req_ready, resp_valid}, 64'h2);
        base_cnt = rd_total;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!resp_valid && t < 300) begin @(negedge clk); t++; end
        chk(resp_valid, "R8 walk completion", {63'd0, resp_valid}, 64'd1);
        chk(!req_ready, "R9 ready low with result", {63'd0, req_ready}, 64'd0);
        got = rd_total - base_cnt;
        chk(got == nexp, efault ? "R7 reads before fault" : "R8 read count",
            64'(got), 64'(nexp));
        for (int k = 0; k < nexp && k < got; k++) begin
            chk(rd_log[(base_cnt + k) & 7] == ea[k],
                (k == 0) ? "R2 root entry address" :
                (k == 1) ? "R3 directory entry address" : "R4 page-table entry address",
                {28'd0, rd_log[(base_cnt + k) & 7]}, {28'd0, ea[k]});
        end
        chk(resp_fault == efault, "R7 fault flag", {63'd0, resp_fault}, {63'd0, efault});
        chk(resp_level == elvl, "R7 level", {62'd0, resp_level}, {62'd0, elvl});
        chk(resp_paddr == epa, efault ? "R7 paddr zero on fault" : "R5 R6 physical address",
            {28'd0, resp_paddr}, {28'd0, epa});
    endtask

    task automatic summary(input int extra);
        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + mchecks + extra, fails + mfails + extra);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        summary(1);
        $finish;
    end

    initial begin
        logic [35:0] roots [3];
        logic [8:0]  dv, tv;
        logic [11:0] ov;
        roots[0] = 36'h0_0000_0000;
        roots[1] = 36'hF_FFFF_FFE0;
        roots[2] = 36'h1_2345_6780;
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        chk(req_ready && !mem_rd_valid && !resp_valid, "R1 in reset",
            {61'd0, req_ready, mem_rd_valid, resp_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_rd_valid && !resp_valid, "R1 after release",
            {61'd0, req_ready, mem_rd_valid, resp_valid}, 64'h4);
        for (int r = 0; r < 3; r++) begin
            for (int tp = 0; tp < 4; tp++) begin
                for (int di = 0; di < 8; di++) begin
                    for (int ti = 0; ti < 8; ti++) begin
                        dv = (di == 7) ? 9'd511 : 9'(di * 73);
                        tv = (ti == 7) ? 9'd511 : 9'(ti * 67);
                        ov = (ti == 7) ? 12'hFFF : 12'(int'(dv) * 5 + int'(tv));
                        run(roots[r], {2'(tp), dv, tv, ov});
                    end
                end
            end
        end
        @(negedge clk);
        chk(!resp_valid && req_ready, "R9 strobe drops after result",
            {62'd0, resp_valid, req_ready}, 64'h1);
        repeat (8) @(negedge clk);
        summary(0);
        $finish;
    end

endmodule